// File: doc/BRIEF.md
# Legacy MDA/VGA Transaction Router

This block sits in a host bridge. It looks at each memory or I/O request that the processor starts and picks one of two targets: the downstream legacy port or the graphics-attach port. Two inputs from the graphics bridge drive the choice. One is a VGA-enable bit. The other is an I/O base/limit window. An 8-bit legacy control register inside the block also takes part. It has two live bits: one opens a memory hole just below 16 MB, and one states that a monochrome display adapter (MDA) sits on the legacy side.

Requests come in on a valid/ready handshake. Each one carries an address, an I/O-or-memory flag and four byte enables. The request port always accepts. Each accepted request gets a registered answer on the next clock edge. The answer holds the route, a hole-hit flag, a flag for addresses outside every legacy range, and an error flag for an illegal configuration. I/O decoding works per enabled byte and ignores address bits 15:10, so every ISA alias of a legacy port matches too.

Top module: `legacy_route`

## Requirements
- R1: After reset, `cfg_rdata` reads 00h, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write through `cfg_we` stores bit 7 (hole enable) and bit 0 (MDA present). Bits 6:1 always read 0, whatever value is written to them.
- R3: `req_ready` stays 1. A request with `req_valid` high at a clock edge gives `rsp_valid` high, with its decision, after that same edge. `rsp_valid` is 0 after an edge where `req_valid` was low.
- R4: When hole enable is 1, a memory request with an address from F00000h to FFFFFFh gives `rsp_hole`=1, `rsp_route`=0 (legacy) and `rsp_not_legacy`=0. When hole enable is 0, the same address is reported as not legacy.
- R5: A memory request from A0000h to BFFFFh goes to graphics (`rsp_route`=1) when VGA enable is 1. The exception is when MDA present is also 1 and the address lies in B0000h–B7FFFh; that request goes to legacy.
- R6: I/O decoding ignores address bits 15:10. An alias of a legacy port is routed exactly like the port itself.
- R7: With VGA enable 1 and MDA present 1, an I/O request goes to legacy if any enabled byte lands on port 3B4h, 3B5h, 3B8h, 3B9h, 3BAh or 3BFh, even when other enabled bytes are VGA ports. I/O requests that touch only VGA ports (3B0h–3BBh other than those, 3C0h–3DFh) go to graphics. Byte enable bit k selects byte address {addr[15:2], k}.
- R8: With VGA enable 0, every MDA or VGA memory or I/O reference goes to legacy.
- R9: With VGA enable 1 and MDA present 0, an I/O request touching 3BCh–3BFh goes to graphics only if its dword address {addr[15:2],00b} lies within `io_base`..`io_limit` inclusive. Otherwise it goes to legacy.
- R10: With VGA enable 0 and MDA present 1, `rsp_cfg_err` is 1 and legacy references go to legacy. In every other combination `rsp_cfg_err` is 0.
- R11: A request outside all legacy ranges and outside an enabled hole gives `rsp_not_legacy`=1 and `rsp_route`=0. This includes an I/O request with no byte enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| vga_en | input | 1 | VGA enable from the graphics bridge |
| io_base | input | 16 | Graphics I/O window base |
| io_limit | input | 16 | Graphics I/O window limit (inclusive) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_addr | input | ADDR_W | Request address (dword-aligned for I/O) |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Decision valid |
| rsp_route | output | 1 | 1 = graphics port, 0 = legacy port |
| rsp_hole | output | 1 | Memory request hit the enabled hole |
| rsp_not_legacy | output | 1 | Request outside all legacy ranges and the hole |
| rsp_cfg_err | output | 1 | Illegal VGA-enable/MDA-present combination |

## Verification
The assertions assume that `vga_en`, `io_base` and `io_limit` hold steady while a request is in flight. They also assume that `cfg_we` is never driven in the same cycle as a request whose decision depends on the register. The routing checks relate each response to the configuration sampled at the request edge. The bench changes `vga_en`, the window and the register only while `req_valid` is low, and it leaves at least one idle edge before the next request. Every request is held for exactly one edge, so each decision can be tied to a single stimulus.

// File: rtl/legacy_route.sv
module legacy_route #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              vga_en,
  input  logic [15:0]       io_base,
  input  logic [15:0]       io_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic              rsp_route,
  output logic              rsp_hole,
  output logic              rsp_not_legacy,
  output logic              rsp_cfg_err
);
  localparam logic [7:0] CFG_MASK = 8'h81;
  localparam int LANES = 4;

  logic hole_en, mdap;
  logic [7:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata & CFG_MASK;
  end
  assign hole_en   = cfg_q[7];
  assign mdap      = cfg_q[0];
  assign cfg_rdata = cfg_q;
  assign req_ready = 1'b1;

  logic [LANES-1:0] mda_l, vga_l, bcf_l, bc_l;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [1:0] OFS = 2'(k);
    logic [9:0] a;
    assign a = {req_addr[9:2], OFS};
    assign mda_l[k] = req_be[k] & (a == 10'h3B4 || a == 10'h3B5 || a == 10'h3B8 ||
                                   a == 10'h3B9 || a == 10'h3BA || a == 10'h3BF);
    assign vga_l[k] = req_be[k] & ((a >= 10'h3B0 && a <= 10'h3BB) ||
                                   (a >= 10'h3C0 && a <= 10'h3DF));
    assign bcf_l[k] = req_be[k] & (a >= 10'h3BC && a <= 10'h3BF);
    assign bc_l[k]  = req_be[k] & (a >= 10'h3BC && a <= 10'h3BE);
  end

  logic [15:0] io_dw;
  logic io_win, io_leg, io_gfx;
  assign io_dw  = {req_addr[15:2], 2'b00};
  assign io_win = (io_dw >= io_base) && (io_dw <= io_limit);
  assign io_leg = |(mda_l | vga_l | bcf_l);

  always_comb begin
    if (!vga_en)        io_gfx = 1'b0;
    else if (!mdap)     io_gfx = (|bcf_l) ? io_win : 1'b1;
    else                io_gfx = !(|mda_l || |bc_l);
  end

  logic mem_vga, mem_mda, mem_hole, mem_gfx;
  assign mem_vga  = req_addr >= ADDR_W'(24'h0A0000) && req_addr <= ADDR_W'(24'h0BFFFF);
  assign mem_mda  = req_addr >= ADDR_W'(24'h0B0000) && req_addr <= ADDR_W'(24'h0B7FFF);
  assign mem_hole = hole_en && req_addr >= ADDR_W'(24'hF00000) && req_addr <= ADDR_W'(24'hFFFFFF);
  assign mem_gfx  = vga_en && mem_vga && !(mdap && mem_mda);

  logic d_route, d_hole, d_nl;
  assign d_route = req_is_io ? (io_leg & io_gfx) : mem_gfx;
  assign d_hole  = !req_is_io && mem_hole;
  assign d_nl    = req_is_io ? !io_leg : !(mem_vga || mem_hole);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_route      <= 1'b0;
      rsp_hole       <= 1'b0;
      rsp_not_legacy <= 1'b0;
      rsp_cfg_err    <= 1'b0;
    end else begin
      rsp_valid <= req_valid & req_ready;
      if (req_valid) begin
        rsp_route      <= d_route;
        rsp_hole       <= d_hole;
        rsp_not_legacy <= d_nl;
        rsp_cfg_err    <= !vga_en && mdap;
      end
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:1] == 6'd0);
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 8'h81));
  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_hole_legacy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hole |-> !rsp_route && !rsp_not_legacy);
  assert_gfx_needs_vga_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !(rsp_route && !$past(vga_en)));
  assert_err_legacy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cfg_err |-> !rsp_route);
  assert_nl_legacy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_not_legacy |-> !rsp_route && !rsp_hole);
endmodule

// File: tb/sim_legacy_route.sv
`timescale 1ns/1ps
module sim_legacy_route;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic vga_en = 1'b0;
  logic [15:0] io_base = '0, io_limit = '0;
  logic req_valid = 1'b0, req_ready, req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic rsp_valid, rsp_route, rsp_hole, rsp_not_legacy, rsp_cfg_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  legacy_route u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic xfer(logic [31:0] a, logic io, logic [3:0] be);
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_is_io = io; req_be = be;
    @(negedge clk); req_valid = 1'b0;
  endtask

  // expected {valid, route, hole, not_legacy, err}
  task automatic req_chk(string tag, logic [31:0] a, logic io, logic [3:0] be, logic [4:0] exp);
    xfer(a, io, be);
    chk(tag, {27'd0, rsp_valid, rsp_route, rsp_hole, rsp_not_legacy, rsp_cfg_err}, {27'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 valid", rsp_valid, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_cfg();
    wr_cfg(8'hFF); chk("R2 write ff", cfg_rdata, 32'h81);
    wr_cfg(8'h7E); chk("R2 reserved", cfg_rdata, 32'h00);
  endtask

  task automatic t_timing();
    vga_en = 1'b1; wr_cfg(8'h00);
    req_chk("R3 resp", 32'hA0000, 1'b0, 4'hF, 5'b11000);
    @(negedge clk); chk("R3 idle", rsp_valid, 0);
  endtask

  task automatic t_hole();
    vga_en = 1'b0; wr_cfg(8'h80);
    req_chk("R4 hole in", 32'hF00010, 1'b0, 4'hF, 5'b10100);
    req_chk("R4 hole top", 32'hFFFFFC, 1'b0, 4'hF, 5'b10100);
    req_chk("R4 below", 32'hEFFFFC, 1'b0, 4'hF, 5'b10010);
    req_chk("R4 above", 32'h1000000, 1'b0, 4'hF, 5'b10010);
    wr_cfg(8'h00);
    req_chk("R4 off", 32'hF00010, 1'b0, 4'hF, 5'b10010);
  endtask

  task automatic t_mem();
    vga_en = 1'b1; wr_cfg(8'h00);
    req_chk("R5 vga mem", 32'hA0000, 1'b0, 4'hF, 5'b11000);
    req_chk("R5 mda mem gfx", 32'hB0000, 1'b0, 4'hF, 5'b11000);
    wr_cfg(8'h01);
    req_chk("R5 mda mem leg", 32'hB7FFC, 1'b0, 4'hF, 5'b10000);
    req_chk("R5 above mda", 32'hB8000, 1'b0, 4'hF, 5'b11000);
    req_chk("R5 top vga", 32'hBFFFC, 1'b0, 4'hF, 5'b11000);
  endtask

  task automatic t_vga_off();
    vga_en = 1'b0; wr_cfg(8'h00);
    req_chk("R8 mem", 32'hA0000, 1'b0, 4'hF, 5'b10000);
    req_chk("R8 io mda", 32'h3B4, 1'b1, 4'h1, 5'b10000);
    req_chk("R8 io 3bc", 32'h3BC, 1'b1, 4'h1, 5'b10000);
  endtask

  task automatic t_alias();
    vga_en = 1'b1; wr_cfg(8'h00);
    req_chk("R6 alias gfx", 32'h7FB4, 1'b1, 4'h1, 5'b11000);
    wr_cfg(8'h01);
    req_chk("R6 alias mda", 32'h07B4, 1'b1, 4'h1, 5'b10000);
    req_chk("R6 alias vga", 32'hFFC0, 1'b1, 4'h1, 5'b11000);
  endtask

  task automatic t_multi();
    vga_en = 1'b1; wr_cfg(8'h01);
    req_chk("R7 vga only", 32'h3B0, 1'b1, 4'hF, 5'b11000);
    req_chk("R7 mix 3b5", 32'h3B4, 1'b1, 4'hE, 5'b10000);
    req_chk("R7 3b6-7", 32'h3B4, 1'b1, 4'hC, 5'b11000);
    req_chk("R7 3ba", 32'h3B8, 1'b1, 4'h4, 5'b10000);
    req_chk("R7 3bf", 32'h3BC, 1'b1, 4'h8, 5'b10000);
  endtask

  task automatic t_window();
    vga_en = 1'b1; wr_cfg(8'h00);
    io_base = 16'h0300; io_limit = 16'h03FF;
    req_chk("R9 in window", 32'h3BC, 1'b1, 4'h1, 5'b11000);
    io_base = 16'h1000; io_limit = 16'h1FFF;
    req_chk("R9 out window", 32'h3BC, 1'b1, 4'h1, 5'b10000);
    req_chk("R9 3bf out", 32'h3BC, 1'b1, 4'h8, 5'b10000);
    req_chk("R9 3c0 unaffected", 32'h3C0, 1'b1, 4'h1, 5'b11000);
  endtask

  task automatic t_illegal();
    vga_en = 1'b0; wr_cfg(8'h01);
    req_chk("R10 io", 32'h3C0, 1'b1, 4'h1, 5'b10001);
    req_chk("R10 mem", 32'hA0000, 1'b0, 4'hF, 5'b10001);
    vga_en = 1'b1;
    req_chk("R10 legal", 32'hA0000, 1'b0, 4'hF, 5'b11000);
  endtask

  task automatic t_nonleg();
    vga_en = 1'b1; wr_cfg(8'h00);
    req_chk("R11 io", 32'h0080, 1'b1, 4'h1, 5'b10010);
    req_chk("R11 mem", 32'h100000, 1'b0, 4'hF, 5'b10010);
    req_chk("R11 no be", 32'h3B4, 1'b1, 4'h0, 5'b10010);
    req_chk("R11 3e0", 32'h3E0, 1'b1, 4'hF, 5'b10010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_timing();
    t_hole();
    t_mem();
    t_vga_off();
    t_alias();
    t_multi();
    t_window();
    t_illegal();
    t_nonleg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule